// File: doc/BRIEF.md
# ADC Serial Host Controller

This block sits on the host side of a 16-bit successive-approximation converter that has a serial port. It drives the converter's convert strobe, its shift clock and its configuration input, and it captures the result from the converter's data output. A high level on the convert strobe starts a conversion. Lowering the strobe turns on the converter's data output, and a fixed burst of shift clocks then moves the result out and a two-bit channel word in, in the same transfer.

On the user side, a request port with valid/ready carries the channel configuration for one cycle. Each finished cycle returns the captured word with a one-cycle `res_valid` pulse. The result port has no back-pressure: the receiver must take the word in the cycle `res_valid` is high. The request port applies back-pressure through `req_ready`, which is high only while the controller is idle.

The word shifted in during a transfer configures the conversion that the following rising edge of the convert strobe starts. Each result therefore belongs to the configuration sent one request earlier, and the controller returns that configuration with the data. The shift-clock half period, the conversion wait and the setup delay before the first clock are parameters counted in system clock cycles.

Top module: `adc_serial_host`

## Requirements
- R1: During and directly after reset, `adc_conv` is 1, `adc_sck` is 0, `adc_sdi` is 0, `req_ready` is 1 and `res_valid` is 0.
- R2: After each rise of `adc_conv`, and after reset, `adc_conv` stays high for at least CONV_CYC clock cycles before it falls.
- R3: At least SETUP_CYC clock cycles pass between a fall of `adc_conv` and the first rise of `adc_sck`.
- R4: Each low window of `adc_conv` contains exactly DATA_W rising edges of `adc_sck`. `adc_sck` is 0 whenever `adc_conv` is 1.
- R5: Every high phase and every low phase of `adc_sck` lasts exactly SCK_HALF clock cycles.
- R6: `adc_sdi` carries the mode bit `req_cfg[1]` (1 = single-ended, 0 = differential) at the first rising `adc_sck` edge and the select bit `req_cfg[0]` at the second. It is 0 at all later edges and whenever `adc_conv` is high. The encodings are: 10 = channel 0 against ground, 11 = channel 1 against ground, 00 = channel 0 minus channel 1, 01 = channel 1 minus channel 0.
- R7: `adc_sdo` is sampled on each rising `adc_sck` edge, most significant bit first. The straight-binary word appears on `res_data` with `res_valid` high for exactly one cycle.
- R8: `res_cfg` equals the configuration accepted with the previous request. For the first result after reset it is 10.
- R9: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from acceptance until the cycle's result is returned.
- R10: `adc_conv` rises in the same cycle that `res_valid` goes high, right after the last falling edge of `adc_sck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request for one convert-and-transfer cycle |
| req_ready | output | 1 | Controller idle; a request can be accepted |
| req_cfg | input | 2 | Channel configuration {mode, select} for the next conversion |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| res_data | output | DATA_W | Captured conversion code |
| res_cfg | output | 2 | Configuration that produced `res_data` |
| adc_conv | output | 1 | Convert strobe to the converter |
| adc_sck | output | 1 | Shift clock to the converter |
| adc_sdi | output | 1 | Configuration bit stream to the converter |
| adc_sdo | input | 1 | Result bit stream from the converter |

## Verification
The bench sweeps all four channel configurations against analog patterns that include zero, full scale, adjacent codes and differences that clip at zero. Because each result belongs to the configuration sent one request earlier, a controller that tagged results with the current request would report the wrong channel on every transition between configurations. A controller that sent one clock too many would meet the trailing zeros from the converter and get the rise count wrong. A controller that lowered the strobe early would break the timed conversion and setup windows that the behavioural converter measures. Bit-order mistakes on either data line show up as wrong codes or wrong configurations captured by the model.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  localparam int CFG_W = 2;
  typedef logic [CFG_W-1:0] chan_cfg_t;
  // Conversion started at power-up measures channel 0 single-ended.
  localparam chan_cfg_t CFG_POWERUP = 2'b10;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SETUP, ST_SHIFT} host_state_t;
endpackage

// File: rtl/adc_sck_gen.sv
module adc_sck_gen #(
  parameter int NBITS    = 16,
  parameter int SCK_HALF = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run,
  output logic                       sck,
  output logic                       rise_stb,
  output logic                       last_fall,
  output logic [$clog2(NBITS)-1:0]   bit_idx
);
  localparam int HCW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam int BCW = $clog2(NBITS);

  logic [HCW-1:0] half_cnt;
  logic [BCW-1:0] bit_cnt;
  logic           sck_r;
  logic           half_term;

  assign half_term = (half_cnt == HCW'(SCK_HALF - 1));
  assign rise_stb  = run && !sck_r && half_term;
  assign last_fall = run && sck_r && half_term && (bit_cnt == BCW'(NBITS - 1));
  assign sck       = sck_r;
  assign bit_idx   = bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_cnt <= '0;
      bit_cnt  <= '0;
      sck_r    <= 1'b0;
    end else if (!run) begin
      half_cnt <= '0;
      bit_cnt  <= '0;
      sck_r    <= 1'b0;
    end else if (half_term) begin
      half_cnt <= '0;
      sck_r    <= ~sck_r;
      if (sck_r) bit_cnt <= bit_cnt + 1'b1;
    end else begin
      half_cnt <= half_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/adc_cfg_tx.sv
module adc_cfg_tx
  import adc_host_pkg::*;
#(
  parameter int BCW = 4
) (
  input  logic           run,
  input  logic [BCW-1:0] bit_idx,
  input  chan_cfg_t      cfg,
  output logic           sdi
);
  // Mode bit goes first, select bit second, zeros after that.
  always_comb begin
    sdi = 1'b0;
    for (int k = 0; k < CFG_W; k++) begin
      if (run && (bit_idx == BCW'(k))) sdi = cfg[CFG_W-1-k];
    end
  end
endmodule

// File: rtl/adc_shift_rx.sv
module adc_shift_rx #(
  parameter int NBITS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap,
  input  logic             sdo,
  output logic [NBITS-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   word <= '0;
    else if (cap) word <= {word[NBITS-2:0], sdo};
  end
endmodule

// File: rtl/adc_serial_host.sv
module adc_serial_host
  import adc_host_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SCK_HALF  = 3,
  parameter int CONV_CYC  = 320,
  parameter int SETUP_CYC = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_cfg,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic [1:0]        res_cfg,
  output logic              adc_conv,
  output logic              adc_sck,
  output logic              adc_sdi,
  input  logic              adc_sdo
);
  localparam int BCW = $clog2(DATA_W);
  localparam int CCW = $clog2(CONV_CYC + 1);
  localparam int SCW = (SETUP_CYC > 1) ? $clog2(SETUP_CYC) : 1;

  host_state_t       state;
  logic [CCW-1:0]    conv_cnt;
  logic [SCW-1:0]    setup_cnt;
  chan_cfg_t         cfg_new, cfg_prev;
  logic              conv_ok, setup_term, run;
  logic              rise_stb, last_fall;
  logic [BCW-1:0]    bit_idx;
  logic [DATA_W-1:0] rx_word;

  assign conv_ok    = (conv_cnt == CCW'(CONV_CYC));
  assign setup_term = (setup_cnt == SCW'(SETUP_CYC - 1));
  assign run        = (state == ST_SHIFT);
  assign req_ready  = (state == ST_IDLE);

  adc_sck_gen #(.NBITS(DATA_W), .SCK_HALF(SCK_HALF)) i_sck (
    .clk(clk), .rst_n(rst_n), .run(run), .sck(adc_sck),
    .rise_stb(rise_stb), .last_fall(last_fall), .bit_idx(bit_idx)
  );

  adc_cfg_tx #(.BCW(BCW)) i_tx (
    .run(run), .bit_idx(bit_idx), .cfg(cfg_new), .sdi(adc_sdi)
  );

  adc_shift_rx #(.NBITS(DATA_W)) i_rx (
    .clk(clk), .rst_n(rst_n), .cap(rise_stb), .sdo(adc_sdo), .word(rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      adc_conv  <= 1'b1;
      conv_cnt  <= '0;
      setup_cnt <= '0;
      cfg_new   <= CFG_POWERUP;
      cfg_prev  <= CFG_POWERUP;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_cfg   <= CFG_POWERUP;
    end else begin
      res_valid <= 1'b0;
      if (adc_conv && !conv_ok) conv_cnt <= conv_cnt + 1'b1;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          cfg_new <= req_cfg;
          state   <= ST_WAIT;
        end
        ST_WAIT: if (conv_ok) begin
          adc_conv  <= 1'b0;
          setup_cnt <= '0;
          state     <= ST_SETUP;
        end
        ST_SETUP: begin
          if (setup_term) state <= ST_SHIFT;
          else            setup_cnt <= setup_cnt + 1'b1;
        end
        ST_SHIFT: if (last_fall) begin
          adc_conv  <= 1'b1;
          conv_cnt  <= '0;
          res_valid <= 1'b1;
          res_data  <= rx_word;
          res_cfg   <= cfg_prev;
          cfg_prev  <= cfg_new;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_serial_host_chk.sv
module adc_serial_host_chk #(
  parameter int DATA_W    = 16,
  parameter int CONV_CYC  = 320,
  parameter int SETUP_CYC = 6
) (
  input logic clk,
  input logic rst_n,
  input logic adc_conv,
  input logic adc_sck,
  input logic adc_sdi,
  input logic req_ready,
  input logic res_valid
);
  logic [31:0] hi_cnt, lo_cnt, rise_cnt;
  logic        sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt   <= '0;
      lo_cnt   <= '0;
      rise_cnt <= '0;
      sck_q    <= 1'b0;
    end else begin
      sck_q <= adc_sck;
      if (adc_conv) begin
        lo_cnt   <= '0;
        rise_cnt <= '0;
        if (hi_cnt < 32'(CONV_CYC)) hi_cnt <= hi_cnt + 1;
      end else begin
        hi_cnt <= '0;
        if (lo_cnt < 32'(SETUP_CYC)) lo_cnt <= lo_cnt + 1;
        if (adc_sck && !sck_q) rise_cnt <= rise_cnt + 1;
      end
    end
  end

  AST_CONV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_conv) |-> hi_cnt >= 32'(CONV_CYC)); // R2
  AST_SCK_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_sck) |-> lo_cnt >= 32'(SETUP_CYC)); // R3
  AST_SCK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    adc_conv |-> !adc_sck); // R4
  AST_RISE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_sck) |-> rise_cnt < 32'(DATA_W)); // R4
  AST_SDI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    adc_conv |-> !adc_sdi); // R6
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R7
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (adc_conv && !adc_sck)); // R9
  AST_VALID_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $rose(adc_conv)); // R10
endmodule

bind adc_serial_host adc_serial_host_chk #(
  .DATA_W(DATA_W), .CONV_CYC(CONV_CYC), .SETUP_CYC(SETUP_CYC)
) i_chk (
  .clk(clk), .rst_n(rst_n), .adc_conv(adc_conv), .adc_sck(adc_sck),
  .adc_sdi(adc_sdi), .req_ready(req_ready), .res_valid(res_valid)
);

// File: tb/test_adc_serial_host.sv
`timescale 1ns/1ps
module test_adc_serial_host;
  localparam int DW = 16;
  localparam int HALF = 3;
  localparam int CONV = 40;
  localparam int SETUP = 6;
  localparam longint TCK = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid = 1'b0;
  logic [1:0] req_cfg = 2'b00;
  logic req_ready, res_valid, adc_conv, adc_sck, adc_sdi, adc_sdo;
  logic [DW-1:0] res_data;
  logic [1:0] res_cfg;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  adc_serial_host #(.DATA_W(DW), .SCK_HALF(HALF), .CONV_CYC(CONV), .SETUP_CYC(SETUP)) i_adc_serial_host (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cfg(req_cfg), .res_valid(res_valid), .res_data(res_data), .res_cfg(res_cfg),
    .adc_conv(adc_conv), .adc_sck(adc_sck), .adc_sdi(adc_sdi), .adc_sdo(adc_sdo)
  );

  function automatic logic [15:0] code_of(input logic [1:0] c, input logic [15:0] a0, input logic [15:0] a1);
    case (c)
      2'b10:   return a0;
      2'b11:   return a1;
      2'b00:   return (a0 > a1) ? a0 - a1 : 16'h0000;
      default: return (a1 > a0) ? a1 - a0 : 16'h0000;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural converter
  logic [15:0] ch0 = 16'h1357;
  logic [15:0] ch1 = 16'h0246;
  logic [1:0]  cur_cfg = 2'b10;
  logic [1:0]  m_cfg_rx = 2'b10;
  logic [15:0] m_code = 16'h0000;
  logic [15:0] m_sh = 16'h0000;
  int          m_rises = 0;
  bit          m_started = 0;
  longint      t_rise = 0, t_fall = 0, t_edge = 0;

  assign adc_sdo = adc_conv ? 1'b1 : m_sh[15];

  always @(posedge adc_conv) begin
    if (m_started) begin
      chk(m_rises == DW, "R4 sck rises per window", m_rises, DW);
      chk(m_cfg_rx == cur_cfg, "R6 cfg bits received", m_cfg_rx, cur_cfg);
    end
    m_code = code_of(m_cfg_rx, ch0, ch1);
    t_rise = $time;
  end

  always @(negedge adc_conv) begin
    if ($time > 0) begin
      chk(($time - t_rise) >= CONV * TCK, "R2 convert high time", $time - t_rise, CONV * TCK);
      m_sh = m_code;
      m_rises = 0;
      t_fall = $time;
      m_started = 1;
    end
  end

  always @(posedge adc_sck) begin
    if (adc_conv === 1'b0) begin
      if (m_rises == 0)
        chk(($time - t_fall) >= SETUP * TCK, "R3 setup before first sck", $time - t_fall, SETUP * TCK);
      else
        chk(($time - t_edge) == HALF * TCK, "R5 sck low phase", $time - t_edge, HALF * TCK);
      if (m_rises == 0)      m_cfg_rx[1] = adc_sdi;
      else if (m_rises == 1) m_cfg_rx[0] = adc_sdi;
      else chk(adc_sdi == 1'b0, "R6 sdi zero after cfg", adc_sdi, 0);
      m_rises++;
      t_edge = $time;
    end
  end

  always @(negedge adc_sck) begin
    if (adc_conv === 1'b0) begin
      chk(($time - t_edge) == HALF * TCK, "R5 sck high phase", $time - t_edge, HALF * TCK);
      m_sh = {m_sh[14:0], 1'b0};
      t_edge = $time;
    end
  end

  logic [15:0] exp_code;
  logic [1:0]  exp_cfg;

  task automatic run_one(input logic [1:0] c, input logic [15:0] a0, input logic [15:0] a1);
    bit busy_ready = 0;
    ch0 = a0;
    ch1 = a1;
    cur_cfg = c;
    req_valid = 1'b1;
    req_cfg = c;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_cfg = 2'b00;
    while (!res_valid) begin
      if (req_ready) busy_ready = 1;
      @(negedge clk);
    end
    chk(!busy_ready, "R9 ready low while busy", busy_ready, 0);
    chk(res_data == exp_code, "R7 result data", res_data, exp_code);
    chk(res_cfg == exp_cfg, "R8 result cfg tag", res_cfg, exp_cfg);
    chk(adc_conv == 1'b1, "R10 convert raised with valid", adc_conv, 1);
    @(negedge clk);
    chk(res_valid == 1'b0, "R7 valid single pulse", res_valid, 0);
    exp_code = code_of(c, a0, a1);
    exp_cfg = c;
  endtask

  initial begin
    rst_n = 1'b0;
    exp_code = code_of(2'b10, ch0, ch1);
    exp_cfg = 2'b10;
    repeat (3) @(negedge clk);
    chk(adc_conv == 1'b1, "R1 reset conv", adc_conv, 1);
    chk(adc_sck == 1'b0, "R1 reset sck", adc_sck, 0);
    chk(adc_sdi == 1'b0, "R1 reset sdi", adc_sdi, 0);
    chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
    chk(res_valid == 1'b0, "R1 reset valid", res_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < 6; p++) begin
        logic [15:0] a0, a1;
        case (p)
          0: begin a0 = 16'h0000; a1 = 16'h0000; end
          1: begin a0 = 16'hFFFF; a1 = 16'h0000; end
          2: begin a0 = 16'h0000; a1 = 16'hFFFF; end
          3: begin a0 = 16'h8000; a1 = 16'h7FFF; end
          4: begin a0 = 16'hA5A5; a1 = 16'h5A5A; end
          default: begin a0 = 16'h1234; a1 = 16'hFEDC; end
        endcase
        run_one(2'(c), a0, a1);
      end
    end
    for (int k = 0; k < 4; k++) run_one(2'(3 - k), 16'h00FF + 16'(k), 16'hF00F);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule